// File: doc/BRIEF.md
# Indirect 64-bit Register Access Bridge

This bridge is a slave on a 32-bit host register bus. Through it the host reaches a bank of 64-bit registers inside a target engine. The host sees two 32-bit data windows. The upper window carries bits 63:32 of a target register and the lower window carries bits 31:0. A command register starts each transfer. Bit 31 of the command word gives the direction: 1 is a write and 0 is a read. Bits 30:0 are the absolute target address, which equals the engine base (`0x70000 + INST_OFS`) plus a register index.

To write a target register, the host loads both windows and then writes the command with bit 31 set. The bridge then drives the 64-bit value and the decoded index to the target for one cycle. To read a target register, the host writes the command with bit 31 clear. The bridge strobes the target, waits `RD_LAT` cycles and loads the returned value into the windows. While a command is in progress, `host_ready` is low. An access that the host presents during that time is held off and is not accepted. As a result, any window read issued after a read command returns the fetched value.

A command address outside the implemented index range does not touch the target. Instead it sets a sticky error flag in status bit 31. The host clears this flag, together with both windows, by writing any value to the clear register. An interrupt enable register gates the error flag onto `irq`.

The sequencer has four states:
- IDLE accepts host accesses.
- PUSH holds the one-cycle target write strobe.
- FETCH holds the one-cycle target read strobe.
- WAIT counts the read latency.

The sequencer has these transitions:
- IDLE→PUSH on a valid write command.
- IDLE→FETCH on a valid read command.
- IDLE→IDLE on an invalid command, which raises the error.
- PUSH→IDLE after one cycle.
- FETCH→WAIT after one cycle.
- WAIT→IDLE when the count reaches `RD_LAT`, at which point the windows are loaded.

Top module: `ixb_bridge`

Host register offsets (byte addresses):

| Offset | Register | Access |
|---|---|---|
| 0x00 | upper data window | read/write |
| 0x04 | lower data window | read/write |
| 0x08 | command | read/write |
| 0x18 | clear | write only, reads 0 |
| 0x1C | status | read only |
| 0x20 | interrupt enable | read/write |

## Requirements
- R1: After reset, every host register reads 0, `host_ready` is 1, and both target strobes are 0.
- R2: The window at offset 0x00 holds target bits 63:32 and the window at 0x04 holds bits 31:0. Each window reads back the last value written to it.
- R3: A write command (bit 31 = 1) to a valid address produces exactly one cycle of `tgt_wr_en`. During that cycle `tgt_wdata` = {window 0x00, window 0x04} and `tgt_idx` = address − base. `tgt_rd_en` stays low.
- R4: A read command (bit 31 = 0) to a valid address produces exactly one cycle of `tgt_rd_en`. `RD_LAT` cycles after that strobe, both windows hold the target value with the R2 bit split. A window read presented right after the command returns the new value.
- R5: A command whose address is below the base, or at or above base + `NUM_REGS`, raises no strobe and leaves the windows unchanged. It sets status bit 31. All other status bits read 0.
- R6: The error flag is sticky: later valid commands do not clear it, and they still execute normally. Any write to offset 0x18 clears the flag and both windows.
- R7: `host_ready` is low while a command runs. After a write command is accepted it is low for 1 cycle. After a read command is accepted it is low for `RD_LAT`+1 cycles. An invalid command causes no stall.
- R8: Bit 0 of the interrupt enable register (offset 0x20) reads back as written. `irq` equals status bit 31 AND that enable bit.
- R9: Reads of unmapped offsets return 0. Writes to unmapped offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| host_req | input | 1 | host access request |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | HADDR_W | host byte offset |
| host_wdata | input | 32 | host write data |
| host_rdata | output | 32 | host read data, valid while the request is accepted |
| host_ready | output | 1 | access is accepted on the clock edge where req and ready are both 1 |
| tgt_wr_en | output | 1 | target write strobe |
| tgt_rd_en | output | 1 | target read strobe |
| tgt_idx | output | IDX_W | target register index |
| tgt_wdata | output | 64 | target write data |
| tgt_rdata | input | 64 | target read data, valid `RD_LAT` cycles after the read strobe |
| irq | output | 1 | error interrupt |

## Verification
The bench exercises the following corner cases:

- **Window read straight after a read command.** A bridge that did not hold the host off would return the stale windows.
- **Stall lengths.** The bench measures the stall after each command kind. An off-by-one in the latency counter shows up as a wrong stall length, or as a capture of the target pipeline one stage early.
- **Addresses just outside the valid range.** The bench uses index `NUM_REGS` and one below the base. A decoder with a loose bound would strobe the target or fail to set the error.
- **Stickiness and the clear register.** The bench runs a valid read with the error already set. A design that cleared the flag on any command would lose the error there. A design whose clear register did not reset the windows would show the old data afterwards.

// File: rtl/ixb_pkg.sv
package ixb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PUSH,
        ST_FETCH,
        ST_WAIT
    } ixb_state_e;

    localparam int HADDR_W = 6;

    localparam logic [HADDR_W-1:0] OFS_WIN_HI = 6'h00;
    localparam logic [HADDR_W-1:0] OFS_WIN_LO = 6'h04;
    localparam logic [HADDR_W-1:0] OFS_CMD    = 6'h08;
    localparam logic [HADDR_W-1:0] OFS_CLR    = 6'h18;
    localparam logic [HADDR_W-1:0] OFS_STAT   = 6'h1C;
    localparam logic [HADDR_W-1:0] OFS_IRQEN  = 6'h20;

    localparam int DIR_BIT = 31;
    localparam int ERR_BIT = 31;

endpackage

// File: rtl/ixb_cmd_decode.sv
module ixb_cmd_decode #(
    parameter int          NUM_REGS  = 10,
    parameter logic [31:0] BASE_ADDR = 32'h0007_0000,
    parameter int          IDX_W     = 4
) (
    input  logic [31:0]      cmd_word,
    output logic             dec_write,
    output logic             dec_valid,
    output logic [IDX_W-1:0] dec_idx
);
    import ixb_pkg::*;

    localparam logic [30:0] BASE = BASE_ADDR[30:0];
    localparam logic [30:0] SPAN = 31'(NUM_REGS);

    logic [30:0] addr;
    logic [30:0] offs;

    always_comb begin
        addr      = cmd_word[30:0];
        offs      = addr - BASE;
        dec_write = cmd_word[DIR_BIT];
        dec_valid = (addr >= BASE) && (offs < SPAN);
        dec_idx   = IDX_W'(offs);
    end

endmodule

// File: rtl/ixb_seq.sv
module ixb_seq #(
    parameter int RD_LAT = 2,
    parameter int IDX_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_go,
    input  logic             dec_write,
    input  logic             dec_valid,
    input  logic [IDX_W-1:0] dec_idx,
    output logic             ready,
    output logic             tgt_wr_en,
    output logic             tgt_rd_en,
    output logic [IDX_W-1:0] tgt_idx,
    output logic             cap_en,
    output logic             err_set
);
    import ixb_pkg::*;

    localparam int            CNT_W    = $clog2(RD_LAT + 1) + 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RD_LAT);

    ixb_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [IDX_W-1:0] idx_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (cmd_go && dec_valid) state_d = dec_write ? ST_PUSH : ST_FETCH;
            ST_PUSH:  state_d = ST_IDLE;
            ST_FETCH: state_d = ST_WAIT;
            ST_WAIT:  if (cnt_q == CNT_LAST) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register, latency counter and latched index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_FETCH)     cnt_q <= CNT_W'(1);
            else if (state_q == ST_WAIT) cnt_q <= cnt_q + 1'b1;
            if (state_q == ST_IDLE && cmd_go && dec_valid) idx_q <= dec_idx;
        end
    end

    // outputs
    always_comb begin
        ready     = 1'b0;
        tgt_wr_en = 1'b0;
        tgt_rd_en = 1'b0;
        cap_en    = 1'b0;
        err_set   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                ready   = 1'b1;
                err_set = cmd_go && !dec_valid;
            end
            ST_PUSH:  tgt_wr_en = 1'b1;
            ST_FETCH: tgt_rd_en = 1'b1;
            ST_WAIT:  cap_en    = (cnt_q == CNT_LAST);
            default:  ready     = 1'b0;
        endcase
        tgt_idx = idx_q;
    end

endmodule

// File: rtl/ixb_host_regs.sv
module ixb_host_regs
    import ixb_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               acc,
    input  logic               wr,
    input  logic [HADDR_W-1:0] addr,
    input  logic [31:0]        wdata,
    output logic [31:0]        rdata,
    output logic               cmd_go,
    output logic [63:0]        win,
    input  logic               cap_en,
    input  logic [63:0]        cap_data,
    input  logic               err_set,
    output logic               err,
    output logic               irq
);

    logic [31:0] win_hi_q, win_lo_q, cmd_q;
    logic        err_q, irq_en_q;
    logic        acc_wr;

    always_comb begin
        acc_wr = acc && wr;
        cmd_go = acc_wr && (addr == OFS_CMD);
        win    = {win_hi_q, win_lo_q};
        err    = err_q;
        irq    = err_q && irq_en_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_hi_q <= '0;
            win_lo_q <= '0;
            cmd_q    <= '0;
            err_q    <= 1'b0;
            irq_en_q <= 1'b0;
        end else begin
            if (cap_en) begin
                win_hi_q <= cap_data[63:32];
                win_lo_q <= cap_data[31:0];
            end
            if (err_set) err_q <= 1'b1;
            if (acc_wr) begin
                unique case (addr)
                    OFS_WIN_HI: win_hi_q <= wdata;
                    OFS_WIN_LO: win_lo_q <= wdata;
                    OFS_CMD:    cmd_q    <= wdata;
                    OFS_IRQEN:  irq_en_q <= wdata[0];
                    OFS_CLR: begin
                        win_hi_q <= '0;
                        win_lo_q <= '0;
                        err_q    <= 1'b0;
                    end
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        unique case (addr)
            OFS_WIN_HI: rdata = win_hi_q;
            OFS_WIN_LO: rdata = win_lo_q;
            OFS_CMD:    rdata = cmd_q;
            OFS_STAT:   rdata = {err_q, 31'd0};
            OFS_IRQEN:  rdata = {31'd0, irq_en_q};
            default:    rdata = '0;
        endcase
    end

endmodule

// File: rtl/ixb_bridge.sv
module ixb_bridge #(
    parameter int          NUM_REGS = 10,
    parameter int          RD_LAT   = 2,
    parameter logic [31:0] INST_OFS = 32'h0,
    parameter int          HADDR_W  = ixb_pkg::HADDR_W,
    parameter int          IDX_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_req,
    input  logic               host_wr,
    input  logic [HADDR_W-1:0] host_addr,
    input  logic [31:0]        host_wdata,
    output logic [31:0]        host_rdata,
    output logic               host_ready,
    output logic               tgt_wr_en,
    output logic               tgt_rd_en,
    output logic [IDX_W-1:0]   tgt_idx,
    output logic [63:0]        tgt_wdata,
    input  logic [63:0]        tgt_rdata,
    output logic               irq
);

    localparam logic [31:0] BASE_ADDR = 32'h0007_0000 + INST_OFS;

    logic             acc, cmd_go, cap_en, err_set, err_flag;
    logic             dec_write, dec_valid;
    logic [IDX_W-1:0] dec_idx;

    assign acc = host_req && host_ready;

    ixb_cmd_decode #(
        .NUM_REGS (NUM_REGS),
        .BASE_ADDR(BASE_ADDR),
        .IDX_W    (IDX_W)
    ) u_dec (
        .cmd_word (host_wdata),
        .dec_write(dec_write),
        .dec_valid(dec_valid),
        .dec_idx  (dec_idx)
    );

    ixb_seq #(
        .RD_LAT(RD_LAT),
        .IDX_W (IDX_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_go   (cmd_go),
        .dec_write(dec_write),
        .dec_valid(dec_valid),
        .dec_idx  (dec_idx),
        .ready    (host_ready),
        .tgt_wr_en(tgt_wr_en),
        .tgt_rd_en(tgt_rd_en),
        .tgt_idx  (tgt_idx),
        .cap_en   (cap_en),
        .err_set  (err_set)
    );

    ixb_host_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .acc     (acc),
        .wr      (host_wr),
        .addr    (host_addr),
        .wdata   (host_wdata),
        .rdata   (host_rdata),
        .cmd_go  (cmd_go),
        .win     (tgt_wdata),
        .cap_en  (cap_en),
        .cap_data(tgt_rdata),
        .err_set (err_set),
        .err     (err_flag),
        .irq     (irq)
    );

endmodule

// File: rtl/ixb_bridge_chk.sv
module ixb_bridge_chk
    import ixb_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               host_req,
    input logic               host_wr,
    input logic [HADDR_W-1:0] host_addr,
    input logic               host_ready,
    input logic               tgt_wr_en,
    input logic               tgt_rd_en,
    input logic               err_flag
);

    logic clr_acc;
    assign clr_acc = host_req && host_ready && host_wr && (host_addr == OFS_CLR);

    // R3
    wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_wr_en |=> !tgt_wr_en);

    // R3
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(tgt_wr_en && tgt_rd_en));

    // R4
    rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_rd_en |=> (!tgt_rd_en && !host_ready));

    // R7
    busy_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_wr_en || tgt_rd_en) |-> !host_ready);

    // R6
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !clr_acc) |=> err_flag);

    // R5
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_flag) |-> (!tgt_wr_en && !tgt_rd_en));

endmodule

bind ixb_bridge ixb_bridge_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_req  (host_req),
    .host_wr   (host_wr),
    .host_addr (host_addr),
    .host_ready(host_ready),
    .tgt_wr_en (tgt_wr_en),
    .tgt_rd_en (tgt_rd_en),
    .err_flag  (err_flag)
);

// File: tb/ixb_bridge_tb.sv
module ixb_bridge_tb;

    localparam int NUM_REGS = 10;
    localparam int RD_LAT   = 2;
    localparam int IDX_W    = 4;
    localparam logic [31:0] BASE = 32'h0007_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0;
    logic        host_wr = 1'b0;
    logic [5:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        host_ready;
    logic        tgt_wr_en, tgt_rd_en, irq;
    logic [IDX_W-1:0] tgt_idx;
    logic [63:0] tgt_wdata, tgt_rdata;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ixb_bridge #(.NUM_REGS(NUM_REGS), .RD_LAT(RD_LAT)) u_dut (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_wr(host_wr),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_ready(host_ready), .tgt_wr_en(tgt_wr_en), .tgt_rd_en(tgt_rd_en),
        .tgt_idx(tgt_idx), .tgt_wdata(tgt_wdata), .tgt_rdata(tgt_rdata), .irq(irq)
    );

    // target model
    logic [63:0] mem [NUM_REGS];
    logic [63:0] rq  [RD_LAT];
    int          wr_cnt = 0, rd_cnt = 0;
    logic [IDX_W-1:0] last_idx;
    logic [63:0] last_data;

    always @(posedge clk) begin
        if (tgt_wr_en) begin
            mem[tgt_idx] <= tgt_wdata;
            wr_cnt    <= wr_cnt + 1;
            last_idx  <= tgt_idx;
            last_data <= tgt_wdata;
        end
        if (tgt_rd_en) begin
            rq[0]  <= mem[tgt_idx];
            rd_cnt <= rd_cnt + 1;
        end
        for (int i = 1; i < RD_LAT; i++) rq[i] <= rq[i-1];
    end
    assign tgt_rdata = rq[RD_LAT-1];

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic hwrite(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        host_req = 1'b1; host_wr = 1'b1; host_addr = a; host_wdata = d;
        #1;
        while (!host_ready) begin @(negedge clk); #1; end
        @(posedge clk); #1;
        host_req = 1'b0; host_wr = 1'b0;
    endtask

    task automatic hread(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        host_req = 1'b1; host_wr = 1'b0; host_addr = a;
        #1;
        while (!host_ready) begin @(negedge clk); #1; end
        d = host_rdata;
        @(posedge clk); #1;
        host_req = 1'b0;
    endtask

    task automatic stall_len(output int n);
        n = 0;
        @(negedge clk); #1;
        while (!host_ready) begin n++; @(negedge clk); #1; end
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R1 ready", 64'(host_ready), 64'd1);
        check("R1 strobes", 64'({tgt_wr_en, tgt_rd_en}), 64'd0);
        hread(6'h00, d); check("R1 win hi", 64'(d), 64'd0);
        hread(6'h04, d); check("R1 win lo", 64'(d), 64'd0);
        hread(6'h08, d); check("R1 cmd", 64'(d), 64'd0);
        hread(6'h1C, d); check("R1 status", 64'(d), 64'd0);
        hread(6'h20, d); check("R1 irq en", 64'(d), 64'd0);
    endtask

    task automatic t_windows();
        logic [31:0] d;
        hwrite(6'h00, 32'hCAFE_0001);
        hwrite(6'h04, 32'h1234_5678);
        hread(6'h00, d); check("R2 win hi", 64'(d), 64'hCAFE_0001);
        hread(6'h04, d); check("R2 win lo", 64'(d), 64'h1234_5678);
    endtask

    task automatic t_write_cmd();
        int n, w0, r0;
        w0 = wr_cnt; r0 = rd_cnt;
        hwrite(6'h08, 32'h8000_0000 | (BASE + 5));
        stall_len(n);
        check("R7 write stall", 64'(n), 64'd1);
        check("R3 write count", 64'(wr_cnt - w0), 64'd1);
        check("R3 read count", 64'(rd_cnt - r0), 64'd0);
        check("R3 idx", 64'(last_idx), 64'd5);
        check("R3 data", last_data, 64'hCAFE_0001_1234_5678);
    endtask

    task automatic t_read_cmd();
        logic [31:0] d;
        int n, r0;
        r0 = rd_cnt;
        hwrite(6'h08, BASE + 3);
        hread(6'h00, d); check("R4 win hi after read", 64'(d), 64'h1122_3344);
        hread(6'h04, d); check("R4 win lo after read", 64'(d), 64'h5566_7788);
        check("R4 read strobes", 64'(rd_cnt - r0), 64'd1);
        hwrite(6'h08, BASE + 5);
        stall_len(n);
        check("R7 read stall", 64'(n), 64'(RD_LAT + 1));
        hread(6'h04, d); check("R4 readback of written reg", 64'(d), 64'h1234_5678);
    endtask

    task automatic t_invalid();
        logic [31:0] d;
        int n, w0, r0;
        w0 = wr_cnt; r0 = rd_cnt;
        hwrite(6'h00, 32'hAAAA_0000);
        hwrite(6'h08, 32'h8000_0000 | (BASE + NUM_REGS));
        stall_len(n);
        check("R7 invalid no stall", 64'(n), 64'd0);
        hread(6'h1C, d); check("R5 status high", 64'(d), 64'h8000_0000);
        hwrite(6'h08, BASE - 1);
        check("R5 no strobes", 64'((wr_cnt - w0) + (rd_cnt - r0)), 64'd0);
        hread(6'h00, d); check("R5 window kept", 64'(d), 64'hAAAA_0000);
    endtask

    task automatic t_sticky_clear();
        logic [31:0] d;
        hwrite(6'h08, BASE + 3);
        hread(6'h00, d); check("R6 read works with error", 64'(d), 64'h1122_3344);
        hread(6'h1C, d); check("R6 error sticky", 64'(d), 64'h8000_0000);
        hwrite(6'h18, 32'h0);
        hread(6'h1C, d); check("R6 error cleared", 64'(d), 64'd0);
        hread(6'h00, d); check("R6 win hi cleared", 64'(d), 64'd0);
        hread(6'h04, d); check("R6 win lo cleared", 64'(d), 64'd0);
    endtask

    task automatic t_irq();
        logic [31:0] d;
        hwrite(6'h20, 32'hFFFF_FFFF);
        hread(6'h20, d); check("R8 enable readback", 64'(d), 64'd1);
        check("R8 irq low without error", 64'(irq), 64'd0);
        hwrite(6'h08, BASE + 12);
        @(negedge clk);
        check("R8 irq on error", 64'(irq), 64'd1);
        hwrite(6'h20, 32'h0);
        @(negedge clk);
        check("R8 irq masked", 64'(irq), 64'd0);
        hwrite(6'h18, 32'h1);
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        hwrite(6'h04, 32'h0BAD_F00D);
        hwrite(6'h0C, 32'hFFFF_FFFF);
        hwrite(6'h10, 32'hFFFF_FFFF);
        hwrite(6'h14, 32'hFFFF_FFFF);
        hread(6'h0C, d); check("R9 unmapped read", 64'(d), 64'd0);
        hread(6'h18, d); check("R9 clear reads zero", 64'(d), 64'd0);
        hread(6'h04, d); check("R9 window untouched", 64'(d), 64'h0BAD_F00D);
        hread(6'h1C, d); check("R9 status untouched", 64'(d), 64'd0);
        hread(6'h20, d); check("R9 enable untouched", 64'(d), 64'd0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        for (int i = 0; i < NUM_REGS; i++) mem[i] = 64'(i) * 64'h0101_0101_0101_0101;
        mem[3] = 64'h1122_3344_5566_7788;
        for (int i = 0; i < RD_LAT; i++) rq[i] = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_windows();
        t_write_cmd();
        t_read_cmd();
        t_invalid();
        t_sticky_clear();
        t_irq();
        t_unmapped();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=hung expected=complete");
        finish_run();
    end

endmodule